// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the arithmetic and logic stage of a 32-bit integer datapath. In one combinational pass it takes a 4-bit operation code and two operands and produces a result and the next condition flags. The second operand reaches it already shifted, together with the shifter's carry-out. The operations are add, subtract and reverse subtract, each with or without the incoming carry, plus bitwise logic, move and move-inverted, and four compare/test operations. The compare/test operations only affect the flags.

The flags form a 4-bit vector `{N, Z, C, V}`, with N in bit 3 and V in bit 0. The caller feeds the current flags back on `flags_in` and stores `flags_out`. When nothing should change, `flags_out` simply repeats `flags_in`. Carry follows the not-borrow rule for subtraction. This lets a pair of 32-bit add-with-carry or subtract-with-carry steps form 64-bit arithmetic.

There are no states or transitions. The block is purely combinational, and the operation code alone selects its behaviour.

Top module: `dp_alu`

## Requirements
- R1: Logic codes: 0 gives A AND B, 1 gives A XOR B, 12 gives A OR B, 14 gives A AND NOT B. Each drives `result` with `result_we`=1.
- R2: Move codes: 13 drives `result` with B, and 15 drives it with NOT B, so moving the inverse of 0 gives 0xFFFFFFFF.
- R3: Code 4 gives A+B, and code 5 gives A+B+C, where C is `flags_in[1]`.
- R4: Code 2 gives A-B, and code 6 gives A-B-(1-C).
- R5: Code 3 gives B-A, and code 7 gives B-A-(1-C).
- R6: Codes 8 (AND test), 9 (XOR test), 10 (compare by subtract A-B) and 11 (compare by add A+B) hold `result_we` at 0. All other codes set it to 1.
- R7: When `set_flags`=0 and the code is not 8 to 11, `flags_out` equals `flags_in`.
- R8: Codes 8 to 11 update the flags even when `set_flags`=0. Code 11 sets the flags from A+B.
- R9: When the flags update, N is bit 31 of the computed value and Z is 1 exactly when that value is zero. `result` carries the computed value for every code.
- R10: For updating arithmetic codes, C is the carry-out of the addition, or 1 when a subtraction produces no borrow. V is 1 on signed overflow.
- R11: For updating logic, move and test codes, C takes `shift_carry` and V keeps `flags_in[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 4 | Operation code |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, already shifted |
| shift_carry | input | 1 | Carry-out of the shifter |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| set_flags | input | 1 | Request a flag update |
| result | output | 32 | Computed value |
| result_we | output | 1 | Result should be written to the destination |
| flags_out | output | 4 | Next flags {N,Z,C,V} |

## Verification
The bench builds the block with the default 32-bit width. At that width the sign bit, the carry out of bit 31 and the overflow boundaries at 0x7FFFFFFF and 0x80000000 can be hit with chosen operands. The vectors cover each code with and without `set_flags` and with both values of the incoming carry. Two-step 64-bit add and subtract chains show that carry and not-borrow propagate correctly from one operation to the next.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_AND    = 4'd0,
        OP_XOR    = 4'd1,
        OP_SUB    = 4'd2,
        OP_RSUB   = 4'd3,
        OP_ADD    = 4'd4,
        OP_ADDC   = 4'd5,
        OP_SUBC   = 4'd6,
        OP_RSUBC  = 4'd7,
        OP_TSTAND = 4'd8,
        OP_TSTXOR = 4'd9,
        OP_CMPSUB = 4'd10,
        OP_CMPADD = 4'd11,
        OP_OR     = 4'd12,
        OP_MOVE   = 4'd13,
        OP_ANDN   = 4'd14,
        OP_MOVEN  = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        CIN_ZERO  = 2'd0,
        CIN_ONE   = 2'd1,
        CIN_CARRY = 2'd2
    } cin_sel_e;

    typedef struct packed {
        logic     is_arith;
        logic     writes;
        logic     swap;
        logic     invert;
        cin_sel_e cin_sel;
    } alu_ctrl_t;

    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import alu_pkg::*;
(
    input  alu_op_e   op,
    output alu_ctrl_t ctrl
);
    always_comb begin
        ctrl = '{is_arith: 1'b0, writes: 1'b1, swap: 1'b0,
                 invert: 1'b0, cin_sel: CIN_ZERO};
        unique case (op)
            OP_SUB:    begin ctrl.is_arith = 1'b1; ctrl.invert = 1'b1; ctrl.cin_sel = CIN_ONE; end
            OP_RSUB:   begin ctrl.is_arith = 1'b1; ctrl.swap = 1'b1; ctrl.invert = 1'b1; ctrl.cin_sel = CIN_ONE; end
            OP_ADD:    begin ctrl.is_arith = 1'b1; end
            OP_ADDC:   begin ctrl.is_arith = 1'b1; ctrl.cin_sel = CIN_CARRY; end
            OP_SUBC:   begin ctrl.is_arith = 1'b1; ctrl.invert = 1'b1; ctrl.cin_sel = CIN_CARRY; end
            OP_RSUBC:  begin ctrl.is_arith = 1'b1; ctrl.swap = 1'b1; ctrl.invert = 1'b1; ctrl.cin_sel = CIN_CARRY; end
            OP_CMPSUB: begin ctrl.is_arith = 1'b1; ctrl.writes = 1'b0; ctrl.invert = 1'b1; ctrl.cin_sel = CIN_ONE; end
            OP_CMPADD: begin ctrl.is_arith = 1'b1; ctrl.writes = 1'b0; end
            OP_TSTAND, OP_TSTXOR: begin ctrl.writes = 1'b0; end
            OP_AND, OP_XOR, OP_OR, OP_MOVE, OP_ANDN, OP_MOVEN: begin end
            default: begin end
        endcase
    end
endmodule

// File: rtl/alu_adder.sv
module alu_adder
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             swap,
    input  logic             invert,
    input  cin_sel_e         cin_sel,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             overflow
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] lhs;
    logic [WIDTH-1:0] rhs;
    logic             cin;
    logic [WIDTH:0]   wide;

    always_comb begin
        lhs = swap ? b : a;
        rhs = swap ? a : b;
        if (invert) rhs = ~rhs;
        unique case (cin_sel)
            CIN_ONE:   cin = 1'b1;
            CIN_CARRY: cin = carry_in;
            default:   cin = 1'b0;
        endcase
        wide      = {1'b0, lhs} + {1'b0, rhs} + {{WIDTH{1'b0}}, cin};
        sum       = wide[MSB:0];
        carry_out = wide[WIDTH];
        overflow  = (lhs[MSB] == rhs[MSB]) && (wide[MSB] != lhs[MSB]);
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y
);
    always_comb begin
        unique case (op)
            OP_AND, OP_TSTAND: y = a & b;
            OP_XOR, OP_TSTXOR: y = a ^ b;
            OP_OR:             y = a | b;
            OP_MOVE:           y = b;
            OP_ANDN:           y = a & ~b;
            OP_MOVEN:          y = ~b;
            default:           y = '0;
        endcase
    end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       opcode,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             shift_carry,
    input  logic [3:0]       flags_in,
    input  logic             set_flags,
    output logic [WIDTH-1:0] result,
    output logic             result_we,
    output logic [3:0]       flags_out
);
    localparam int MSB = WIDTH - 1;

    alu_op_e          op;
    alu_ctrl_t        ctrl;
    logic [WIDTH-1:0] arith_y;
    logic [WIDTH-1:0] logic_y;
    logic             arith_c;
    logic             arith_v;
    logic             update;

    assign op = alu_op_e'(opcode);

    alu_op_decode u_decode (
        .op   (op),
        .ctrl (ctrl)
    );

    alu_adder #(.WIDTH(WIDTH)) u_adder (
        .a         (op_a),
        .b         (op_b),
        .swap      (ctrl.swap),
        .invert    (ctrl.invert),
        .cin_sel   (ctrl.cin_sel),
        .carry_in  (flags_in[FLAG_C]),
        .sum       (arith_y),
        .carry_out (arith_c),
        .overflow  (arith_v)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .op (op),
        .a  (op_a),
        .b  (op_b),
        .y  (logic_y)
    );

    always_comb begin
        result    = ctrl.is_arith ? arith_y : logic_y;
        result_we = ctrl.writes;
        update    = set_flags | ~ctrl.writes;
        flags_out = flags_in;
        if (update) begin
            flags_out[FLAG_N] = result[MSB];
            flags_out[FLAG_Z] = (result == '0);
            flags_out[FLAG_C] = ctrl.is_arith ? arith_c : shift_carry;
            flags_out[FLAG_V] = ctrl.is_arith ? arith_v : flags_in[FLAG_V];
        end
    end
endmodule

// File: rtl/dp_alu_checker.sv
module dp_alu_checker #(
    parameter int WIDTH = 32
) (
    input logic [3:0]       opcode,
    input logic [WIDTH-1:0] op_b,
    input logic             shift_carry,
    input logic [3:0]       flags_in,
    input logic             set_flags,
    input logic [WIDTH-1:0] result,
    input logic             result_we,
    input logic [3:0]       flags_out
);
    logic is_test;
    logic is_logic;
    logic upd;

    always_comb begin
        is_test  = (opcode[3:2] == 2'b10);
        is_logic = (opcode <= 4'd1) || (opcode[3:2] == 2'b11) || (opcode[3:1] == 3'b100);
        upd      = set_flags || is_test;
        AST_TEST_NO_WRITE: assert (!is_test || !result_we);  // R6
        AST_OTHERS_WRITE: assert (is_test || result_we);  // R6
        AST_FLAGS_HOLD: assert (upd || flags_out == flags_in);  // R7
        AST_N_FROM_RESULT: assert (!upd || flags_out[3] == result[WIDTH-1]);  // R9
        AST_Z_FROM_RESULT: assert (!upd || flags_out[2] == (result == '0));  // R9
        AST_LOGIC_V_KEEP: assert (!is_logic || flags_out[0] == flags_in[0]);  // R11
        AST_LOGIC_C_SHIFT: assert (!(is_logic && upd) || flags_out[1] == shift_carry);  // R11
        AST_MOVE_PASS: assert (opcode != 4'd13 || result == op_b);  // R2
    end
endmodule

bind dp_alu dp_alu_checker #(.WIDTH(WIDTH)) u_dp_alu_checker (
    .opcode      (opcode),
    .op_b        (op_b),
    .shift_carry (shift_carry),
    .flags_in    (flags_in),
    .set_flags   (set_flags),
    .result      (result),
    .result_we   (result_we),
    .flags_out   (flags_out)
);

// File: tb/test_dp_alu.sv
module test_dp_alu;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 22;

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic        shc;
        logic [3:0]  fin;
        logic        s;
        logic [31:0] res;
        logic        we;
        logic [3:0]  fout;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{4'd4,  32'h00000001, 32'h00000002, 1'b0, 4'b0000, 1'b1, 32'h00000003, 1'b1, 4'b0000}, // R3
        '{4'd4,  32'hFFFFFFFF, 32'h00000001, 1'b0, 4'b0000, 1'b1, 32'h00000000, 1'b1, 4'b0110}, // R10
        '{4'd4,  32'h7FFFFFFF, 32'h00000001, 1'b0, 4'b0000, 1'b1, 32'h80000000, 1'b1, 4'b1001}, // R10
        '{4'd5,  32'h00000005, 32'h00000006, 1'b0, 4'b0010, 1'b1, 32'h0000000C, 1'b1, 4'b0000}, // R3
        '{4'd2,  32'h00000005, 32'h00000003, 1'b0, 4'b0000, 1'b1, 32'h00000002, 1'b1, 4'b0010}, // R4
        '{4'd2,  32'h00000003, 32'h00000005, 1'b0, 4'b0000, 1'b1, 32'hFFFFFFFE, 1'b1, 4'b1000}, // R10
        '{4'd2,  32'h80000000, 32'h00000001, 1'b0, 4'b0000, 1'b1, 32'h7FFFFFFF, 1'b1, 4'b0011}, // R10
        '{4'd6,  32'h0000000A, 32'h00000003, 1'b0, 4'b0000, 1'b1, 32'h00000006, 1'b1, 4'b0010}, // R4
        '{4'd3,  32'h00000003, 32'h0000000A, 1'b0, 4'b1111, 1'b0, 32'h00000007, 1'b1, 4'b1111}, // R5 R7
        '{4'd7,  32'h00000003, 32'h0000000A, 1'b0, 4'b0000, 1'b1, 32'h00000006, 1'b1, 4'b0010}, // R5
        '{4'd0,  32'hF0F0F0F0, 32'hFF00FF00, 1'b1, 4'b0001, 1'b1, 32'hF000F000, 1'b1, 4'b1011}, // R1 R11
        '{4'd1,  32'hFFFF0000, 32'hFFFF0000, 1'b0, 4'b0010, 1'b1, 32'h00000000, 1'b1, 4'b0100}, // R1 R9
        '{4'd12, 32'h0000000F, 32'h000000F0, 1'b0, 4'b0101, 1'b0, 32'h000000FF, 1'b1, 4'b0101}, // R1 R7
        '{4'd14, 32'hFFFFFFFF, 32'h0000FFFF, 1'b0, 4'b0000, 1'b1, 32'hFFFF0000, 1'b1, 4'b1000}, // R1
        '{4'd13, 32'h0000DEAD, 32'h12345678, 1'b1, 4'b0000, 1'b1, 32'h12345678, 1'b1, 4'b0010}, // R2
        '{4'd15, 32'h00000000, 32'h00000000, 1'b0, 4'b0000, 1'b1, 32'hFFFFFFFF, 1'b1, 4'b1000}, // R2
        '{4'd8,  32'h0000000F, 32'h000000F0, 1'b1, 4'b0001, 1'b0, 32'h00000000, 1'b0, 4'b0111}, // R6 R8
        '{4'd9,  32'h00000001, 32'h00000001, 1'b0, 4'b1000, 1'b0, 32'h00000000, 1'b0, 4'b0100}, // R6 R8
        '{4'd10, 32'h00000005, 32'h00000005, 1'b0, 4'b0000, 1'b0, 32'h00000000, 1'b0, 4'b0110}, // R8
        '{4'd11, 32'hFFFFFFFF, 32'h00000001, 1'b0, 4'b0000, 1'b0, 32'h00000000, 1'b0, 4'b0110}, // R8
        '{4'd11, 32'h00000001, 32'h00000001, 1'b0, 4'b1111, 1'b0, 32'h00000002, 1'b0, 4'b0000}, // R8
        '{4'd5,  32'hFFFFFFFF, 32'h00000000, 1'b0, 4'b0010, 1'b1, 32'h00000000, 1'b1, 4'b0110}  // R3
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  opcode = '0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        shift_carry = 1'b0;
    logic [3:0]  flags_in = '0;
    logic        set_flags = 1'b0;
    logic [31:0] result;
    logic        result_we;
    logic [3:0]  flags_out;
    int checks = 0;
    int errors = 0;
    logic [3:0] saved;

    always #(CLK_PERIOD/2) clk = ~clk;

    dp_alu i_dp_alu (
        .opcode(opcode), .op_a(op_a), .op_b(op_b), .shift_carry(shift_carry),
        .flags_in(flags_in), .set_flags(set_flags),
        .result(result), .result_we(result_we), .flags_out(flags_out)
    );

    task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic shc, input logic [3:0] fin, input logic s);
        @(posedge clk);
        opcode = op; op_a = a; op_b = b; shift_carry = shc; flags_in = fin; set_flags = s;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] er, input logic ew, input logic [3:0] ef);
        checks++;
        if (result !== er || result_we !== ew || flags_out !== ef) begin
            errors++;
            $display("FAIL %s op=%0d got res=%h we=%b flags=%b exp res=%h we=%b flags=%b",
                     req, opcode, result, result_we, flags_out, er, ew, ef);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // Idle input state: AND of zeros, no flag request (R1 R7)
        apply(4'd0, 32'h0, 32'h0, 1'b0, 4'b0000, 1'b0);
        check("R1_R7 idle", 32'h0, 1'b1, 4'b0000);

        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].shc, VECS[i].fin, VECS[i].s);
            check($sformatf("vec%0d R1..R11", i), VECS[i].res, VECS[i].we, VECS[i].fout);
        end

        // R3 R10: 64-bit add 0x1_FFFFFFFF + 0x2_00000001 = 0x4_00000000
        apply(4'd4, 32'hFFFFFFFF, 32'h00000001, 1'b0, 4'b0000, 1'b1);
        check("R3 low add", 32'h0, 1'b1, 4'b0110);
        saved = flags_out;
        apply(4'd5, 32'h00000001, 32'h00000002, 1'b0, saved, 1'b1);
        check("R3 high add", 32'h4, 1'b1, 4'b0000);

        // R4 R10: 64-bit sub 0x1_00000000 - 1 = 0x0_FFFFFFFF
        apply(4'd2, 32'h00000000, 32'h00000001, 1'b0, 4'b0000, 1'b1);
        check("R4 low sub", 32'hFFFFFFFF, 1'b1, 4'b1000);
        saved = flags_out;
        apply(4'd6, 32'h00000001, 32'h00000000, 1'b0, saved, 1'b1);
        check("R4 high sub", 32'h0, 1'b1, 4'b0110);

        // R7: arithmetic without set_flags leaves flags alone
        apply(4'd4, 32'h7FFFFFFF, 32'h00000001, 1'b0, 4'b0110, 1'b0);
        check("R7 add no S", 32'h80000000, 1'b1, 4'b0110);

        // R11: move with S keeps V, takes C from shifter
        apply(4'd13, 32'h0, 32'h0, 1'b0, 4'b1011, 1'b1);
        check("R11 move zero", 32'h0, 1'b1, 4'b0101);

        // R5: RSUBC with carry set, borrow case 1-2 = -1
        apply(4'd7, 32'h00000002, 32'h00000001, 1'b0, 4'b0010, 1'b1);
        check("R5 rsubc borrow", 32'hFFFFFFFF, 1'b1, 4'b1000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule